// File: doc/BRIEF.md
# Skip-Linked PWM Buffer Transfer Controller

This block governs when a compare value that software has placed in a buffer register may move on into a temporary register of a center-aligned complementary PWM timer. The carrier counter supplies one-cycle pulses at each crest and each trough. The block keeps one interrupt-skipping counter per event type. Each counter has its own enable and its own programmable count. From these counters the block forms a transfer window. A two-bit mode input then decides whether buffer-to-temporary moves happen freely, are held back entirely, or are allowed only while the window is open.

In linked mode the compare update rate follows the decimated interrupt rate instead of every carrier half-period. Software writes the buffer after a skipped interrupt. The value stays pending until the window admits it. It then reaches the compare register at the next carrier event.

Top module: `pwm_buf_xfer_ctrl`

## Requirements
- R1: While reset is high and after it falls, every output reads 0 (window, load strobe, both interrupt requests, temporary and compare data).
- R2: With a skip enable at 1 and its count N in 1..7, that event type's interrupt request pulses for one cycle, in the cycle after every Nth event, and the counter then starts again.
- R3: An event type whose skip enable is 0 or whose count is 0 is inactive: its request pulses in the cycle after every one of its events, and its events never open or close the window.
- R4: The window goes high in the cycle after an active counter reaches its count. It goes low in the cycle after an event of an active type that does not reach its count. It stays low while neither type is active.
- R5: A buffer write captures the data and marks it pending. In mode 00 or 11 the load strobe pulses, and the temporary data takes the captured value, two cycles after the write cycle.
- R6: In mode 01 no load takes place. The pending value is kept and loads once a free mode (00) is selected again.
- R7: In mode 10 a pending value loads only in the cycle after one in which the window is high.
- R8: In mode 10 with both event types inactive, the load strobe never pulses and the temporary data never changes.
- R9: In the cycle after any crest or trough event, the compare data equals the temporary data of the event cycle, in every mode.
- R10: A change of a skip count clears that counter, so the count restarts from zero with the new value.
- R11: A write in the same cycle as a load leaves the new value pending, and it loads on the next allowed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| crest_evt | input | 1 | Carrier crest pulse |
| trough_evt | input | 1 | Carrier trough pulse |
| xfer_mode | input | 2 | 00/11 free, 01 hold, 10 linked to skipping |
| crest_skip_en | input | 1 | Crest counter defines the window |
| trough_skip_en | input | 1 | Trough counter defines the window |
| crest_skip_cnt | input | CNT_W | Crest skip count (0 = inactive) |
| trough_skip_cnt | input | CNT_W | Trough skip count (0 = inactive) |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | DATA_W | Buffer write data |
| xfer_window | output | 1 | Transfer-enabled window |
| tmp_load | output | 1 | Temporary register load pulse |
| crest_irq | output | 1 | Skipped crest interrupt request |
| trough_irq | output | 1 | Skipped trough interrupt request |
| tmp_data | output | DATA_W | Temporary register |
| cmp_data | output | DATA_W | Compare register |

## Verification
The bench builds the block with DATA_W = 16 and CNT_W = 3, so the full skip range 1..7 and the zero count that marks a counter inactive can be programmed directly. With 16-bit data, every load has a distinct value, so a missed, early or doubled load shows up in the compared data. It also covers a skip-count change partway through a count and back-to-back writes that meet a load.

// File: rtl/pwm_xfer_pkg.sv
package pwm_xfer_pkg;
  typedef enum logic [1:0] {
    XM_FREE     = 2'b00,
    XM_HOLD     = 2'b01,
    XM_LINKED   = 2'b10,
    XM_FREE_ALT = 2'b11
  } xfer_mode_e;

  localparam int NUM_EVT = 2;
  localparam int EVT_CREST  = 0;
  localparam int EVT_TROUGH = 1;
endpackage

// File: rtl/pwm_skip_ctr.sv
module pwm_skip_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             active,
  output logic             fire,
  output logic             step,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit_q;
  logic             changed;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);
  assign changed = (limit != limit_q);
  assign active  = en && (limit != '0);
  assign fire    = evt && active && !changed && (cnt_inc == limit);
  assign step    = evt && active && !changed && !fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      limit_q <= '0;
      irq     <= 1'b0;
    end else begin
      limit_q <= limit;
      irq     <= fire || (evt && !active);
      if (!active || changed || fire)
        cnt <= '0;
      else if (step)
        cnt <= cnt_inc;
    end
  end
endmodule

// File: rtl/pwm_xfer_buffer.sv
module pwm_xfer_buffer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              allow,
  input  logic              any_evt,
  output logic              load,
  output logic [DATA_W-1:0] tmp_q,
  output logic [DATA_W-1:0] cmp_q
);
  logic [DATA_W-1:0] buf_q;
  logic              pend;
  logic              do_load;

  assign do_load = pend && allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      pend  <= 1'b0;
      tmp_q <= '0;
      cmp_q <= '0;
      load  <= 1'b0;
    end else begin
      load <= do_load;
      if (do_load)
        tmp_q <= buf_q;
      if (any_evt)
        cmp_q <= tmp_q;
      if (wr) begin
        buf_q <= wdata;
        pend  <= 1'b1;
      end else if (do_load) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_buf_xfer_ctrl.sv
module pwm_buf_xfer_ctrl #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crest_evt,
  input  logic              trough_evt,
  input  logic [1:0]        xfer_mode,
  input  logic              crest_skip_en,
  input  logic              trough_skip_en,
  input  logic [CNT_W-1:0]  crest_skip_cnt,
  input  logic [CNT_W-1:0]  trough_skip_cnt,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic              xfer_window,
  output logic              tmp_load,
  output logic              crest_irq,
  output logic              trough_irq,
  output logic [DATA_W-1:0] tmp_data,
  output logic [DATA_W-1:0] cmp_data
);
  import pwm_xfer_pkg::*;

  logic [NUM_EVT-1:0] evt_v, en_v, act_v, fire_v, step_v, irq_v;
  logic [CNT_W-1:0]   lim_v [NUM_EVT];
  xfer_mode_e         mode;
  logic               allow;

  assign evt_v[EVT_CREST]  = crest_evt;
  assign evt_v[EVT_TROUGH] = trough_evt;
  assign en_v[EVT_CREST]   = crest_skip_en;
  assign en_v[EVT_TROUGH]  = trough_skip_en;
  assign lim_v[EVT_CREST]  = crest_skip_cnt;
  assign lim_v[EVT_TROUGH] = trough_skip_cnt;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_skip
    pwm_skip_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_v[g]),
      .en     (en_v[g]),
      .limit  (lim_v[g]),
      .active (act_v[g]),
      .fire   (fire_v[g]),
      .step   (step_v[g]),
      .irq    (irq_v[g])
    );
  end

  assign crest_irq  = irq_v[EVT_CREST];
  assign trough_irq = irq_v[EVT_TROUGH];

  always_ff @(posedge clk) begin
    if (rst)
      xfer_window <= 1'b0;
    else if (act_v == '0)
      xfer_window <= 1'b0;
    else if (fire_v != '0)
      xfer_window <= 1'b1;
    else if (step_v != '0)
      xfer_window <= 1'b0;
  end

  assign mode = xfer_mode_e'(xfer_mode);

  always_comb begin
    case (mode)
      XM_HOLD:   allow = 1'b0;
      XM_LINKED: allow = xfer_window;
      default:   allow = 1'b1;
    endcase
  end

  pwm_xfer_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr      (buf_wr),
    .wdata   (buf_wdata),
    .allow   (allow),
    .any_evt (crest_evt || trough_evt),
    .load    (tmp_load),
    .tmp_q   (tmp_data),
    .cmp_q   (cmp_data)
  );
endmodule

// File: rtl/pwm_xfer_chk.sv
module pwm_xfer_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              crest_evt,
  input logic              trough_evt,
  input logic [1:0]        xfer_mode,
  input logic              crest_skip_en,
  input logic              trough_skip_en,
  input logic [CNT_W-1:0]  crest_skip_cnt,
  input logic [CNT_W-1:0]  trough_skip_cnt,
  input logic              xfer_window,
  input logic              tmp_load,
  input logic              crest_irq,
  input logic              trough_irq,
  input logic [DATA_W-1:0] tmp_data,
  input logic [DATA_W-1:0] cmp_data
);
  logic both_idle;
  assign both_idle = !(crest_skip_en && crest_skip_cnt != '0) &&
                     !(trough_skip_en && trough_skip_cnt != '0);

  p_hold_no_load_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode == 2'b01) |=> !tmp_load);

  p_linked_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode == 2'b10 && !xfer_window) |=> !tmp_load);

  p_idle_closed_r4: assert property (@(posedge clk) disable iff (rst)
    both_idle |=> !xfer_window);

  p_crest_irq_src_r2: assert property (@(posedge clk) disable iff (rst)
    crest_irq |-> $past(crest_evt));

  p_trough_irq_src_r2: assert property (@(posedge clk) disable iff (rst)
    trough_irq |-> $past(trough_evt));

  p_cmp_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (crest_evt || trough_evt) |=> (cmp_data == $past(tmp_data)));

  p_tmp_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !tmp_load |-> $stable(tmp_data));
endmodule

bind pwm_buf_xfer_ctrl pwm_xfer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .crest_evt(crest_evt), .trough_evt(trough_evt),
  .xfer_mode(xfer_mode), .crest_skip_en(crest_skip_en),
  .trough_skip_en(trough_skip_en), .crest_skip_cnt(crest_skip_cnt),
  .trough_skip_cnt(trough_skip_cnt), .xfer_window(xfer_window),
  .tmp_load(tmp_load), .crest_irq(crest_irq), .trough_irq(trough_irq),
  .tmp_data(tmp_data), .cmp_data(cmp_data)
);

// File: tb/sim_pwm_buf_xfer_ctrl.sv
module sim_pwm_buf_xfer_ctrl;
  localparam int DW = 16;
  localparam int CW = 3;

  logic clk = 0, rst = 1;
  logic crest_evt = 0, trough_evt = 0;
  logic [1:0] xfer_mode = 2'b00;
  logic crest_skip_en = 0, trough_skip_en = 0;
  logic [CW-1:0] crest_skip_cnt = 0, trough_skip_cnt = 0;
  logic buf_wr = 0;
  logic [DW-1:0] buf_wdata = 0;
  logic xfer_window, tmp_load, crest_irq, trough_irq;
  logic [DW-1:0] tmp_data, cmp_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_buf_xfer_ctrl #(.DATA_W(DW), .CNT_W(CW)) u0 (.*);

  // behavioural reference
  int m_cnt[2], m_last[2];
  bit m_irq[2];
  bit m_win, m_pend, m_load;
  int m_buf, m_tmp, m_cmp;

  always @(posedge clk) begin
    bit ev[2], en[2], act[2];
    int lim[2];
    bit fire, stp, anyact, allow;
    int old_tmp;
    ev[0] = crest_evt; ev[1] = trough_evt;
    en[0] = crest_skip_en; en[1] = trough_skip_en;
    lim[0] = crest_skip_cnt; lim[1] = trough_skip_cnt;
    if (rst) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_last[i] = 0; m_irq[i] = 0; end
      m_win = 0; m_pend = 0; m_load = 0; m_buf = 0; m_tmp = 0; m_cmp = 0;
    end else begin
      fire = 0; stp = 0; anyact = 0;
      allow = (xfer_mode == 2'b01) ? 1'b0 : (xfer_mode == 2'b10) ? m_win : 1'b1;
      for (int i = 0; i < 2; i++) begin
        act[i] = en[i] && lim[i] != 0;
        anyact |= act[i];
        m_irq[i] = 0;
        if (!act[i]) begin
          m_cnt[i] = 0;
          if (ev[i]) m_irq[i] = 1;
        end else if (lim[i] != m_last[i]) begin
          m_cnt[i] = 0;
        end else if (ev[i]) begin
          if (m_cnt[i] + 1 == lim[i]) begin m_irq[i] = 1; m_cnt[i] = 0; fire = 1; end
          else begin m_cnt[i]++; stp = 1; end
        end
        m_last[i] = lim[i];
      end
      if (!anyact) m_win = 0;
      else if (fire) m_win = 1;
      else if (stp) m_win = 0;
      old_tmp = m_tmp;
      m_load = m_pend && allow;
      if (m_load) begin m_tmp = m_buf; m_pend = 0; end
      if (ev[0] || ev[1]) m_cmp = old_tmp;
      if (buf_wr) begin m_buf = buf_wdata; m_pend = 1; end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk("R2 crest_irq", crest_irq, m_irq[0]);
      chk("R2 trough_irq", trough_irq, m_irq[1]);
      chk("R4 window", xfer_window, m_win);
      chk("R5 tmp_load", tmp_load, m_load);
      chk("R5 tmp_data", tmp_data, m_tmp);
      chk("R9 cmp_data", cmp_data, m_cmp);
    end
    if (cyc > 20000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit c, bit t);
    @(negedge clk); crest_evt = c; trough_evt = t;
    @(negedge clk); crest_evt = 0; trough_evt = 0;
  endtask

  task automatic wr(int d);
    @(negedge clk); buf_wr = 1; buf_wdata = DW'(d);
    @(negedge clk); buf_wr = 0;
  endtask

  initial begin
    idle(3);
    chk("R1 window", xfer_window, 0);
    chk("R1 tmp", tmp_data, 0);
    @(negedge clk); rst = 0;
    idle(1);
    chk("R1 irq", crest_irq | trough_irq | tmp_load, 0);
    chk("R1 cmp", cmp_data, 0);

    // free mode
    wr(16'h1111); idle(1);
    chk("R5 free load", tmp_data, 16'h1111);
    pulse(1, 0);
    chk("R9 cmp after crest", cmp_data, 16'h1111);
    xfer_mode = 2'b11; wr(16'h2222); idle(1);
    chk("R5 mode 11 load", tmp_data, 16'h2222);

    // skipping crest count 3, trough inactive
    crest_skip_en = 1; crest_skip_cnt = 3; idle(2);
    for (int k = 0; k < 7; k++) begin pulse(1, 0); idle(1); end
    pulse(0, 1);
    chk("R3 trough passes", trough_irq, 1);
    pulse(0, 1);
    chk("R3 trough leaves window", xfer_window, m_win);

    // linked mode, crest count 2
    rst = 1; idle(2); rst = 0;
    xfer_mode = 2'b10; crest_skip_en = 1; crest_skip_cnt = 2; idle(2);
    wr(16'h3333); idle(3);
    chk("R7 closed no load", tmp_data, 0);
    pulse(1, 0);
    chk("R7 still closed", xfer_window, 0);
    pulse(1, 0);
    chk("R2 crest irq at count", crest_irq, 1);
    chk("R4 window open", xfer_window, 1);
    idle(1);
    chk("R7 load in window", tmp_data, 16'h3333);
    pulse(1, 0);
    chk("R4 window closed", xfer_window, 0);

    // hold mode
    xfer_mode = 2'b01; wr(16'h4444); idle(2);
    pulse(1, 1); pulse(1, 0); idle(2);
    chk("R6 hold keeps tmp", tmp_data, 16'h3333);
    xfer_mode = 2'b00; idle(2);
    chk("R6 released", tmp_data, 16'h4444);

    // linked with skipping inactive
    xfer_mode = 2'b10; crest_skip_en = 0; trough_skip_en = 1; trough_skip_cnt = 0;
    idle(2); wr(16'h5555);
    for (int k = 0; k < 6; k++) begin pulse(1, 1); idle(1); end
    chk("R8 no load", tmp_data, 16'h4444);
    chk("R8 window low", xfer_window, 0);

    // count change clears counter
    xfer_mode = 2'b00; crest_skip_en = 1; crest_skip_cnt = 3; idle(2);
    pulse(1, 0); pulse(1, 0);
    crest_skip_cnt = 2; idle(2);
    pulse(1, 0);
    chk("R10 restart no irq", crest_irq, 0);
    pulse(1, 0);
    chk("R10 irq at new count", crest_irq, 1);

    // back-to-back writes meeting a load
    @(negedge clk); buf_wr = 1; buf_wdata = 16'hAAAA;
    @(negedge clk); buf_wdata = 16'hBBBB;
    @(negedge clk); buf_wr = 0;
    chk("R11 first load", tmp_data, 16'hAAAA);
    @(negedge clk);
    chk("R11 second load", tmp_data, 16'hBBBB);

    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule